// File: doc/BRIEF.md
# Chainable Four-Channel Periodic Timer Group

This block holds four down-counting timers that all advance on one shared prescaled tick taken from the system clock. Each timer loads a start value from its base-count register and counts down. When it reaches its terminal count it reloads and raises a one-cycle interrupt pulse, so it keeps firing periodically until software holds it again through the inhibit bit (bit 31 of base count). Each timer also has a vector/priority word and a destination word. The block only stores these two words so that the interrupt controller beside it can read them.

A group control register selects the prescaler ratio. It can also join two neighbouring timers into one longer timer. In a joined pair the lower-numbered timer counts single ticks. The higher-numbered timer counts the borrows of the lower one, and only the higher timer raises the pair's interrupt. With the rollover bit of the pair set, the remaining time of the pair is upper × 0xFFFFFFFF + lower.

The register port is a plain single-cycle port. A write takes effect on the clock edge where `wr_en` is high. Read data appears on `rdata` in the cycle after `rd_en`. There is no streaming interface and no back-pressure: every access completes at once.

Top module: `tqg_top`

## Requirements
- R1: After reset the group control, vector, destination and current-count registers read 0, every base-count register reads 0x8000_0000 (inhibited), and `irq` is 0.
- R2: Byte address layout: timer n sits at n×0x40, with current count at +0x00, base count at +0x10, vector/priority at +0x20 and destination at +0x30. Group control is at 0x100. Only bits 2:0, 9:8 and 26:24 of group control are stored. Vector and destination keep all 32 bits. Every other address reads 0. `rdata` is valid one cycle after `rd_en`.
- R3: The group control bits 9:8 select the tick period: 0 gives 8 clocks, 1 gives 16, 2 gives 32 and 3 gives 64.
- R4: While base bit 31 is 1 the timer's count holds. On the first tick after bit 31 is cleared, the count loads base bits 30:0.
- R5: A running unchained timer with base value B (bits 30:0) pulses its interrupt every max(B,1) ticks, reloading from base each time.
- R6: Any write to a current-count register sets that count to 0.
- R7: Group control bit p (p = 0, 1, 2) joins timer p (lower) with timer p+1 (upper). Bit p takes effect only when pair p−1 is not joined. A joined pair counts only while the upper timer's inhibit bit is clear. The lower timer of a joined pair never pulses its interrupt.
- R8: In a joined pair whose rollover bit (24+p) is set, the count reaches the lower timer at zero. The next tick then decrements the upper timer and refills the lower with 0xFFFFFFFE, so upper × 0xFFFFFFFF + lower falls by exactly one per tick.
- R9: With the rollover bit clear, the lower timer refills from its own 32-bit base value L. The pair's interrupt period is then H×(L+1)+L ticks, where H is the upper base bits 30:0.
- R10: Every interrupt pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 9 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 4 | Per-timer interrupt pulses, active high |

## Verification
The checker watches four things on every clock. Interrupt pulses last one cycle, and prescaler ticks never come back to back. An inhibited top timer keeps its count unless software writes it. Reserved reads return zero, and the lower timer of pair 0 stays silent. The bench scenarios show the other behaviour. This covers the exact period for each divider and base value, and the load after the inhibit bit is cleared. It also covers the borrow-and-refill arithmetic of a joined pair in both rollover settings, and the rule that decides between overlapping pair enables.

// File: rtl/tqg_pkg.sv
package tqg_pkg;
  localparam int NT       = 4;
  localparam int DW       = 32;
  localparam int ADDR_W   = 9;
  localparam logic [ADDR_W-1:0] GCR_ADDR = 9'h100;
  localparam logic [DW-1:0] GCR_MASK = 32'h0700_0307;
  localparam logic [DW-1:0] ROLL_REFILL = 32'hFFFF_FFFE;
  localparam int ROLL_POS = 24;
  localparam int RATIO_LO = 8;

  typedef enum logic [1:0] {
    REG_CUR  = 2'd0,
    REG_BASE = 2'd1,
    REG_VEC  = 2'd2,
    REG_DST  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    MODE_SOLO = 2'd0,
    MODE_LO   = 2'd1,
    MODE_HI   = 2'd2
  } chan_mode_e;
endpackage

// File: rtl/tqg_prescale.sv
module tqg_prescale #(
  parameter int PSC_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ratio,
  output logic       tick
);
  logic [PSC_W-1:0] pc_q;
  logic [PSC_W-1:0] lim;

  always_comb begin
    lim  = PSC_W'((32'd8 << ratio) - 32'd1);
    tick = (pc_q >= lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else if (tick) pc_q <= '0;
    else pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/tqg_chan.sv
module tqg_chan
  import tqg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         start,
  input  logic         clr,
  input  chan_mode_e   mode,
  input  logic [W-1:0] base,
  input  logic [W-1:0] peer,
  input  logic [W-1:0] refill,
  output logic [W-1:0] cnt,
  output logic         fire
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] ld_val;
  logic cnt_z, cnt_le1, peer_z, peer_le1, term, step;

  always_comb begin
    ld_val   = (mode == MODE_LO) ? base : {1'b0, base[W-2:0]};
    cnt_z    = (cnt_q == '0);
    cnt_le1  = (cnt_q <= W'(1));
    peer_z   = (peer == '0);
    peer_le1 = (peer <= W'(1));
    case (mode)
      MODE_HI: term = cnt_z && peer_le1;
      MODE_LO: term = peer_z && cnt_le1;
      default: term = cnt_le1;
    endcase
    step = tick && run && !start && !clr;
    fire = step && term && (mode != MODE_LO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (tick && run) begin
      if (start || term) cnt_q <= ld_val;
      else begin
        case (mode)
          MODE_HI: if (peer_z) cnt_q <= cnt_q - 1'b1;
          MODE_LO: cnt_q <= cnt_z ? refill : cnt_q - 1'b1;
          default: cnt_q <= cnt_q - 1'b1;
        endcase
      end
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tqg_top.sv
module tqg_top
  import tqg_pkg::*;
#(
  parameter int PSC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [NT-1:0]     irq
);
  localparam int NP = NT - 1;

  logic                 tick;
  logic [DW-1:0]        gcr_q;
  logic [NT-1:0][DW-1:0] base_q, vec_q, dst_q, cnt_q;
  logic [NT-1:0]        loaded_q, clr, fire, irq_q;
  logic [NP-1:0]        pair_act;
  logic [NT-1:0]        is_lo, is_hi;
  logic                 tmr_hit, grp_hit;
  logic [1:0]           tsel;
  reg_sel_e             rsel;
  logic [DW-1:0]        rd_val;

  always_comb begin
    tsel    = addr[7:6];
    rsel    = reg_sel_e'(addr[5:4]);
    tmr_hit = !addr[8] && (addr[3:0] == 4'd0);
    grp_hit = (addr == GCR_ADDR);
  end

  tqg_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .ratio(gcr_q[9:8]), .tick(tick)
  );

  always_comb begin
    pair_act[0] = gcr_q[0];
    for (int p = 1; p < NP; p++) pair_act[p] = gcr_q[p] && !pair_act[p-1];
    is_lo = {1'b0, pair_act};
    is_hi = {pair_act, 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcr_q  <= '0;
      base_q <= {NT{32'h8000_0000}};
      vec_q  <= '0;
      dst_q  <= '0;
    end else if (wr_en) begin
      if (grp_hit) gcr_q <= wdata & GCR_MASK;
      else if (tmr_hit) begin
        case (rsel)
          REG_BASE: base_q[tsel] <= wdata;
          REG_VEC:  vec_q[tsel]  <= wdata;
          REG_DST:  dst_q[tsel]  <= wdata;
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) loaded_q <= '0;
    else begin
      for (int i = 0; i < NT; i++) begin
        if (base_q[i][DW-1]) loaded_q[i] <= 1'b0;
        else if (tick) loaded_q[i] <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NT; i++) begin : g_chan
    localparam int UP = (i + 1) % NT;
    localparam int DN = (i + NT - 1) % NT;
    chan_mode_e   md;
    logic         run_i, start_i;
    logic [DW-1:0] peer_i, refill_i;

    always_comb begin
      clr[i] = wr_en && tmr_hit && (tsel == 2'(i)) && (rsel == REG_CUR);
      if (is_lo[i]) begin
        md       = MODE_LO;
        run_i    = !base_q[UP][DW-1];
        start_i  = !loaded_q[UP];
        peer_i   = cnt_q[UP];
        refill_i = gcr_q[ROLL_POS + (i % NP)] ? ROLL_REFILL : base_q[i];
      end else if (is_hi[i]) begin
        md       = MODE_HI;
        run_i    = !base_q[i][DW-1];
        start_i  = !loaded_q[i];
        peer_i   = cnt_q[DN];
        refill_i = '0;
      end else begin
        md       = MODE_SOLO;
        run_i    = !base_q[i][DW-1];
        start_i  = !loaded_q[i];
        peer_i   = '0;
        refill_i = '0;
      end
    end

    tqg_chan #(.W(DW)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run_i), .start(start_i),
      .clr(clr[i]), .mode(md), .base(base_q[i]), .peer(peer_i),
      .refill(refill_i), .cnt(cnt_q[i]), .fire(fire[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else irq_q <= fire;
  end

  always_comb begin
    rd_val = '0;
    if (grp_hit) rd_val = gcr_q;
    else if (tmr_hit) begin
      case (rsel)
        REG_CUR:  rd_val = cnt_q[tsel];
        REG_BASE: rd_val = base_q[tsel];
        REG_VEC:  rd_val = vec_q[tsel];
        default:  rd_val = dst_q[tsel];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_val;
    else rdata <= '0;
  end

  assign irq = irq_q;
endmodule

// File: rtl/tqg_checker.sv
module tqg_checker
  import tqg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DW-1:0]     rdata,
  input logic [NT-1:0]     irq,
  input logic              tick,
  input logic [DW-1:0]     gcr_q,
  input logic [DW-1:0]     base3,
  input logic [DW-1:0]     cnt3
);
  logic rsv;
  logic wr_cnt3;
  always_comb begin
    rsv = addr[8] ? (addr != GCR_ADDR) : (addr[3:0] != 4'd0);
    wr_cnt3 = wr_en && (addr == 9'h0C0);
  end

  for (genvar i = 0; i < NT; i++) begin : g_pulse
    p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |=> !irq[i]);
  end

  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rsv) |=> (rdata == '0));

  p_hold_inhibit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (base3[DW-1] && !wr_cnt3) |=> $stable(cnt3));

  p_lower_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(gcr_q[0]) |-> !irq[0]);
endmodule

bind tqg_top tqg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .irq(irq), .tick(tick), .gcr_q(gcr_q),
  .base3(base_q[3]), .cnt3(cnt_q[3])
);

// File: tb/test_tqg_top.sv
module test_tqg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int checks = 0, errors = 0, cyc = 0;
  int pulses [4] = '{0, 0, 0, 0};

  tqg_top i_tqg_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;
  always @(negedge clk) for (int j = 0; j < 4; j++) if (irq[j]) pulses[j]++;

  function automatic int div_of(int r);
    return 8 << r;
  endfunction
  function automatic int solo_period(int b, int r);
    return ((b == 0) ? 1 : b) * div_of(r);
  endfunction
  function automatic int pair_period(int h, int l, int r);
    return (h * (l + 1) + l) * div_of(r);
  endfunction

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wait_irq(int k, int lim, output int at);
    at = -1;
    for (int c = 0; c < lim; c++) begin
      @(negedge clk);
      if (irq[k]) begin at = cyc; return; end
    end
  endtask

  task automatic measure(int k, int lim, output int dt);
    int a, b;
    wait_irq(k, lim, a);
    @(negedge clk);
    check("R10 pulse width", {31'd0, irq[k]}, 32'd0);
    wait_irq(k, lim, b);
    dt = (a < 0 || b < 0) ? -1 : b - a;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, d2, rv;
    int dt, t, b, r, p0, p1, p2;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", {28'd0, irq}, 32'd0);
    rd(9'h100, d); check("R1 gcr", d, 32'h0);
    rd(9'h010, d); check("R1 base0", d, 32'h8000_0000);
    rd(9'h0D0, d); check("R1 base3", d, 32'h8000_0000);
    rd(9'h080, d); check("R1 cnt2", d, 32'h0);
    rd(9'h0E0, d); check("R1 vec3", d, 32'h0);

    // R2 layout, masks and reserved space
    rv = $urandom; wr(9'h060, rv); rd(9'h060, d); check("R2 vec1", d, rv);
    rv = $urandom; wr(9'h0B0, rv); rd(9'h0B0, d); check("R2 dst2", d, rv);
    wr(9'h100, 32'hFFFF_FFFF); rd(9'h100, d); check("R2 gcr mask", d, 32'h0700_0307);
    wr(9'h100, 32'h0);
    rd(9'h104, d); check("R2 reserved 0x104", d, 32'h0);
    rd(9'h068, d); check("R2 reserved 0x068", d, 32'h0);
    rd(9'h184, d); check("R2 reserved 0x184", d, 32'h0);

    // R3 / R5 random solo periods
    for (int n = 0; n < 12; n++) begin
      t = $urandom_range(0, 3); b = $urandom_range(1, 12); r = $urandom_range(0, 3);
      wr(9'h100, 32'(r) << 8);
      wr(9'(t * 64 + 16), 32'(b));
      measure(t, (b + 3) * div_of(r) * 2, dt);
      check("R3 R5 period", 32'(dt), 32'(solo_period(b, r)));
      wr(9'(t * 64 + 16), 32'h8000_0000 | 32'(b));
    end

    // R5 base of zero fires every tick
    wr(9'h100, 32'h0000_0100);
    wr(9'h050, 32'h0);
    measure(1, 200, dt);
    check("R5 zero base", 32'(dt), 32'(solo_period(0, 1)));
    wr(9'h050, 32'h8000_0000);

    // R4 hold while inhibited, R6 clear by write
    wr(9'h100, 32'h0);
    wr(9'h050, 32'd1000);
    repeat (200) @(negedge clk);
    wr(9'h050, 32'h8000_0000 | 32'd1000);
    rd(9'h040, d);
    repeat (100) @(negedge clk);
    rd(9'h040, d2);
    check("R4 hold", d2, d);
    check("R4 loaded from base", {31'd0, (d <= 32'd1000 && d >= 32'd960)}, 32'd1);
    wr(9'h040, 32'h1234_5678);
    rd(9'h040, d); check("R6 clear", d, 32'h0);
    wr(9'h050, 32'd5);
    measure(1, 400, dt);
    check("R4 restart period", 32'(dt), 32'(solo_period(5, 0)));
    wr(9'h050, 32'h8000_0005);

    // R7 / R9 joined pair 2-3, rollover clear
    wr(9'h100, 32'h0000_0004);
    wr(9'h080, 32'h0); wr(9'h0C0, 32'h0);
    wr(9'h0D0, 32'h8000_0002);
    wr(9'h090, 32'd3);
    repeat (100) @(negedge clk);
    rd(9'h080, d); check("R7 lower held by upper inhibit", d, 32'h0);
    p2 = pulses[2];
    wr(9'h0D0, 32'd2);
    measure(3, 400, dt);
    check("R9 pair period", 32'(dt), 32'(pair_period(2, 3, 0)));
    check("R7 lower silent", 32'(pulses[2] - p2), 32'h0);
    wr(9'h0D0, 32'h8000_0002);

    // R8 joined pair 0-1, rollover set
    wr(9'h100, 32'h0100_0001);
    wr(9'h000, 32'h0); wr(9'h040, 32'h0);
    wr(9'h050, 32'h8000_0001);
    wr(9'h010, 32'd2);
    p0 = pulses[0]; p1 = pulses[1];
    wr(9'h050, 32'd1);
    repeat (80) @(negedge clk);
    wr(9'h050, 32'h8000_0001);
    rd(9'h040, d); check("R8 upper borrowed", d, 32'h0);
    rd(9'h000, d);
    check("R8 lower refilled", {31'd0, (d >= 32'hFFFF_FFF4 && d <= 32'hFFFF_FFFC)}, 32'd1);
    check("R7 no pulses pair0", 32'((pulses[0] - p0) + (pulses[1] - p1)), 32'h0);

    // R7 overlapping enables: pair 0 wins, timer 2 runs alone
    wr(9'h100, 32'h0000_0003);
    wr(9'h090, 32'd4);
    measure(2, 200, dt);
    check("R7 precedence solo timer2", 32'(dt), 32'(solo_period(4, 0)));
    wr(9'h090, 32'h8000_0004);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule